// File: doc/BRIEF.md
# Tournament Hybrid Branch Direction Predictor

This block produces a taken/not-taken guess for a branch from two component predictors and a per-entry chooser that decides which of them to trust. The first component is local: a table of 64 ten-bit history registers, picked by the low PC bits, records each branch's own recent outcomes. That history then indexes a table of 2-bit saturating counters. The second component is global: the global history supplied by the caller is XORed with the PC bits, and the result indexes a second table of 2-bit counters.

Lookup is purely combinational. The caller presents the PC bits and the current global history, and receives in the same cycle the final guess and both component guesses. The caller keeps the component guesses and the global history it used, and returns them with the resolved outcome on the update port. Every resolved branch trains both counter tables and the local history register, whichever component was selected. The chooser entry for that PC then moves according to which component turned out to be right.

Each chooser entry is a four-state machine. The states are `CH_P1_STRONG`, `CH_P1_WEAK`, `CH_P2_WEAK` and `CH_P2_STRONG`, with numeric encodings 0 to 3. The two P1 states follow the local guess and the two P2 states follow the global guess. There are three kinds of transition. A **hold** happens when both components were right or both were wrong. A **step-to-global** (correctness pair 0/1) moves one state toward `CH_P2_STRONG`. A **step-to-local** (pair 1/0) moves one state toward `CH_P1_STRONG`. Both steps saturate at the end states.

Top module: `hybrid_dir_pred`

## Requirements
- R1: After reset, every counter in both tables holds 01 (weakly not-taken), every local history register is zero, and every chooser entry is `CH_P1_WEAK`. Every lookup therefore returns 0 on all three outputs.
- R2: Lookup outputs depend combinationally on the lookup inputs and the current table contents. An update accepted at a rising clock edge is visible to lookups from that edge on.
- R3: `lk_p1` is the MSB of the local counter indexed by the 10-bit history register that `lk_pc[5:0]` selects.
- R4: On an update, the local counter at the selected register's current history moves one step toward the outcome, saturating at 0 and 3. That register then shifts left by one bit, with the outcome (1 = taken) entering bit 0.
- R5: `lk_p2` is the MSB of the global counter at index `lk_pc ^ lk_ghist`. An update moves the counter at `up_pc ^ up_ghist` one step toward the outcome, saturating at 0 and 3.
- R6: The chooser entry is indexed by `lk_pc[5:0]`. `lk_taken` equals `lk_p1` in states 0 and 1 and equals `lk_p2` in states 2 and 3.
- R7: The correctness bits are c1 = (`up_p1` == `up_taken`) and c2 = (`up_p2` == `up_taken`). Pairs 0/0 and 1/1 leave the chooser entry at `up_pc[5:0]` unchanged.
- R8: Pair 0/1 raises the chooser entry by one state, up to a maximum of 3. Pair 1/0 lowers it by one state, down to a minimum of 0.
- R9: Both counter tables and the local history are trained on every update, independent of the chooser state.
- R10: While `up_valid` is 0, no table or history changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 10 | Low PC bits of the branch being predicted |
| lk_ghist | input | 10 | Global history used for this lookup |
| lk_taken | output | 1 | Final direction guess (1 = taken) |
| lk_p1 | output | 1 | Local component guess |
| lk_p2 | output | 1 | Global component guess |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | 10 | Low PC bits of the resolved branch |
| up_ghist | input | 10 | Global history that was used at its lookup |
| up_taken | input | 1 | Actual outcome (1 = taken) |
| up_p1 | input | 1 | Local guess returned at lookup |
| up_p2 | input | 1 | Global guess returned at lookup |

## Verification
The chooser state can only be seen at the ports when the two component guesses differ for the same PC, and every update also trains the local history and the counters that decide those guesses. To handle this, the stimulus first drives one global counter to strongly taken through a PC whose chooser entry is otherwise unused, and leaves another global counter untouched. It then looks up the target PC twice, with global histories aimed at each of those two counters, so one lookup yields a global guess of 1 and the other a guess of 0. One of the two then disagrees with the local guess, which exposes the chooser's selection. The correctness pair on the update port is set freely through `up_p1`/`up_p2`, which walks each entry through every state and every pair, including both saturation ends.

// File: rtl/hp_pkg.sv
package hp_pkg;
    typedef enum logic [1:0] {
        CH_P1_STRONG = 2'd0,
        CH_P1_WEAK   = 2'd1,
        CH_P2_WEAK   = 2'd2,
        CH_P2_STRONG = 2'd3
    } choice_e;

    localparam logic [1:0] CTR_INIT = 2'b01;
endpackage

// File: rtl/hp_ctr_table.sv
module hp_ctr_table
    import hp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    logic [1:0] ctr_q [DEPTH];
    logic [1:0] rd_ctr;
    logic [1:0] cur;
    logic [1:0] nxt;

    assign rd_ctr   = ctr_q[rd_idx];
    assign rd_taken = rd_ctr[1];
    assign cur      = ctr_q[wr_idx];

    always_comb begin
        nxt = cur;
        if (wr_taken) begin
            if (cur != 2'b11) nxt = cur + 2'd1;
        end else begin
            if (cur != 2'b00) nxt = cur - 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
        end else if (we) begin
            ctr_q[wr_idx] <= nxt;
        end
    end

    // R4 / R5: a taken outcome never lowers the counter, a not-taken one never raises it
    a_r5_no_drop_on_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_taken) |=> ctr_q[$past(wr_idx)] >= $past(cur));
    a_r5_no_rise_on_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wr_taken) |=> ctr_q[$past(wr_idx)] <= $past(cur));
    // R10: idle update port keeps the entry that is being read
    a_r10_idle_table: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ctr_q[$past(rd_idx)] == $past(rd_ctr));
endmodule

// File: rtl/hp_local_hist.sv
module hp_local_hist #(
    parameter int SEL_W  = 6,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              we,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              wr_taken,
    output logic [HIST_W-1:0] wr_hist
);
    localparam int NREG = 1 << SEL_W;

    logic [HIST_W-1:0] hist_q [NREG];

    assign rd_hist = hist_q[rd_sel];
    assign wr_hist = hist_q[wr_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) hist_q[i] <= '0;
        end else if (we) begin
            hist_q[wr_sel] <= {wr_hist[HIST_W-2:0], wr_taken};
        end
    end

    // R4: newest outcome lands in bit 0, older bits move up by one
    a_r4_newest_bit: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> hist_q[$past(wr_sel)][0] == $past(wr_taken));
    a_r4_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> hist_q[$past(wr_sel)][1] == $past(wr_hist[0]));
endmodule

// File: rtl/hp_chooser.sv
module hp_chooser
    import hp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_use_p2,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             c1,
    input  logic             c2
);
    localparam int DEPTH = 1 << IDX_W;

    choice_e st_q [DEPTH];
    choice_e rd_state;
    choice_e cur;
    choice_e nxt;

    assign rd_state = st_q[rd_idx];
    assign cur      = st_q[wr_idx];

    // next-state logic for the entry under update
    always_comb begin
        nxt = cur;
        unique case ({c1, c2})
            2'b01: begin
                unique case (cur)
                    CH_P1_STRONG: nxt = CH_P1_WEAK;
                    CH_P1_WEAK:   nxt = CH_P2_WEAK;
                    CH_P2_WEAK:   nxt = CH_P2_STRONG;
                    CH_P2_STRONG: nxt = CH_P2_STRONG;
                endcase
            end
            2'b10: begin
                unique case (cur)
                    CH_P1_STRONG: nxt = CH_P1_STRONG;
                    CH_P1_WEAK:   nxt = CH_P1_STRONG;
                    CH_P2_WEAK:   nxt = CH_P1_WEAK;
                    CH_P2_STRONG: nxt = CH_P2_WEAK;
                endcase
            end
            default: nxt = cur;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) st_q[i] <= CH_P1_WEAK;
        end else if (we) begin
            st_q[wr_idx] <= nxt;
        end
    end

    // output decode
    always_comb begin
        unique case (rd_state)
            CH_P1_STRONG, CH_P1_WEAK: rd_use_p2 = 1'b0;
            CH_P2_WEAK, CH_P2_STRONG: rd_use_p2 = 1'b1;
        endcase
    end

    a_r7_hold_on_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (c1 == c2)) |=> st_q[$past(wr_idx)] == $past(cur));
    a_r8_toward_global: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !c1 && c2) |=> st_q[$past(wr_idx)] >= $past(cur));
    a_r8_toward_local: assert property (@(posedge clk) disable iff (!rst_n)
        (we && c1 && !c2) |=> st_q[$past(wr_idx)] <= $past(cur));
    a_r10_idle_chooser: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> st_q[$past(rd_idx)] == $past(rd_state));
endmodule

// File: rtl/hybrid_dir_pred.sv
module hybrid_dir_pred #(
    parameter int GH_W     = 10,
    parameter int LH_SEL_W = 6,
    parameter int LH_W     = 10,
    parameter int CH_W     = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [GH_W-1:0] lk_pc,
    input  logic [GH_W-1:0] lk_ghist,
    output logic            lk_taken,
    output logic            lk_p1,
    output logic            lk_p2,
    input  logic            up_valid,
    input  logic [GH_W-1:0] up_pc,
    input  logic [GH_W-1:0] up_ghist,
    input  logic            up_taken,
    input  logic            up_p1,
    input  logic            up_p2
);
    localparam int PC_W = GH_W;

    logic [LH_W-1:0] lk_hist;
    logic [LH_W-1:0] up_hist;
    logic            use_p2;
    logic            c1;
    logic            c2;

    assign c1 = (up_p1 == up_taken);
    assign c2 = (up_p2 == up_taken);

    hp_local_hist #(.SEL_W(LH_SEL_W), .HIST_W(LH_W)) u_lhist (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel   (lk_pc[LH_SEL_W-1:0]),
        .rd_hist  (lk_hist),
        .we       (up_valid),
        .wr_sel   (up_pc[LH_SEL_W-1:0]),
        .wr_taken (up_taken),
        .wr_hist  (up_hist)
    );

    hp_ctr_table #(.IDX_W(LH_W)) u_local_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_hist),
        .rd_taken (lk_p1),
        .we       (up_valid),
        .wr_idx   (up_hist),
        .wr_taken (up_taken)
    );

    hp_ctr_table #(.IDX_W(PC_W)) u_global_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_pc ^ lk_ghist),
        .rd_taken (lk_p2),
        .we       (up_valid),
        .wr_idx   (up_pc ^ up_ghist),
        .wr_taken (up_taken)
    );

    hp_chooser #(.IDX_W(CH_W)) u_choose (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_pc[CH_W-1:0]),
        .rd_use_p2 (use_p2),
        .we        (up_valid),
        .wr_idx    (up_pc[CH_W-1:0]),
        .c1        (c1),
        .c2        (c2)
    );

    assign lk_taken = use_p2 ? lk_p2 : lk_p1;

    // R6: final guess always agrees with one of the two component guesses
    a_r6_follows_component: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_p1 == lk_p2) |-> (lk_taken == lk_p1));
endmodule

// File: tb/sim_hybrid_dir_pred.sv
module sim_hybrid_dir_pred;
    localparam int W     = 10;
    localparam int NLOC  = 64;
    localparam int NTAB  = 1024;
    localparam int G_HOT = 1000;
    localparam int G_ICE = 3;
    localparam int G_DMP = 500;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] lk_pc = '0, lk_ghist = '0, up_pc = '0, up_ghist = '0;
    logic         up_valid = 1'b0, up_taken = 1'b0, up_p1 = 1'b0, up_p2 = 1'b0;
    logic         lk_taken, lk_p1, lk_p2;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int m_lh [NLOC];
    int m_lc [NTAB];
    int m_gc [NTAB];
    int m_ch [NLOC];

    always #5 clk = ~clk;

    hybrid_dir_pred u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_ghist(lk_ghist),
        .lk_taken(lk_taken), .lk_p1(lk_p1), .lk_p2(lk_p2),
        .up_valid(up_valid), .up_pc(up_pc), .up_ghist(up_ghist),
        .up_taken(up_taken), .up_p1(up_p1), .up_p2(up_p2)
    );

    function automatic int sat(input int v, input bit tk);
        if (tk) return (v < 3) ? v + 1 : 3;
        return (v > 0) ? v - 1 : 0;
    endfunction

    function automatic bit e_p1(input int pc);
        return m_lc[m_lh[pc % NLOC]] >= 2;
    endfunction

    function automatic bit e_p2(input int pc, input int gh);
        return m_gc[(pc ^ gh) % NTAB] >= 2;
    endfunction

    function automatic bit e_tk(input int pc, input int gh);
        return (m_ch[pc % NLOC] >= 2) ? e_p2(pc, gh) : e_p1(pc);
    endfunction

    // R2: lookup is combinational, so outputs are sampled 1 ns after driving, mid-cycle
    task automatic look(input int pc, input int gh, input string tag);
        bit xp1, xp2, xtk;
        @(negedge clk);
        lk_pc = W'(pc);
        lk_ghist = W'(gh);
        #1;
        xp1 = e_p1(pc);
        xp2 = e_p2(pc, gh);
        xtk = e_tk(pc, gh);
        n_vec++;
        if (lk_p1 !== xp1 || lk_p2 !== xp2 || lk_taken !== xtk) begin
            n_bad++;
            if (lk_p1 !== xp1)
                $display("FAIL R3 R4 [%s] pc=%0d lk_p1 actual=%b expected=%b", tag, pc, lk_p1, xp1);
            if (lk_p2 !== xp2)
                $display("FAIL R5 [%s] pc=%0d gh=%0d lk_p2 actual=%b expected=%b", tag, pc, gh, lk_p2, xp2);
            if (lk_taken !== xtk)
                $display("FAIL R6 R7 R8 [%s] pc=%0d gh=%0d lk_taken actual=%b expected=%b",
                         tag, pc, gh, lk_taken, xtk);
        end
    endtask

    // R9: the model trains both tables on every valid update; R10: nothing when invalid
    task automatic upd(input int pc, input int gh, input bit tk, input bit p1, input bit p2,
                       input bit vld);
        int li, gi, c;
        @(negedge clk);
        up_pc = W'(pc); up_ghist = W'(gh); up_taken = tk;
        up_p1 = p1; up_p2 = p2; up_valid = vld;
        @(posedge clk);
        #1;
        up_valid = 1'b0;
        if (vld) begin
            li = m_lh[pc % NLOC];
            m_lc[li] = sat(m_lc[li], tk);
            m_lh[pc % NLOC] = ((li << 1) | int'(tk)) % NTAB;
            gi = (pc ^ gh) % NTAB;
            m_gc[gi] = sat(m_gc[gi], tk);
            c = m_ch[pc % NLOC];
            if (p1 != tk && p2 == tk) m_ch[pc % NLOC] = (c < 3) ? c + 1 : 3;
            if (p1 == tk && p2 != tk) m_ch[pc % NLOC] = (c > 0) ? c - 1 : 0;
        end
    endtask

    // drive one chooser pair (c1,c2) at pc with a given outcome
    task automatic pair(input int pc, input int code, input bit tk);
        bit c1, c2;
        c1 = code[1];
        c2 = code[0];
        upd(pc, G_DMP ^ pc, tk, c1 ? tk : !tk, c2 ? tk : !tk, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (R2) actual=timeout expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int seq [16];
        int lfsr;
        seq = '{1, 1, 1, 1, 2, 2, 2, 2, 2, 0, 3, 1, 0, 2, 3, 1};
        for (int i = 0; i < NLOC; i++) begin m_lh[i] = 0; m_ch[i] = 1; end
        for (int i = 0; i < NTAB; i++) begin m_lc[i] = 1; m_gc[i] = 1; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen through many lookups
        for (int i = 0; i < NTAB; i += 13) look(i, (i * 7) % NTAB, "R1 reset");

        // prime one global counter strongly taken from pc 1023 (chooser entry 63), hold pair 0/0
        for (int k = 0; k < 3; k++) upd(1023, G_HOT ^ 1023, 1'b1, 1'b0, 1'b0, 1'b1);
        look(1023, G_HOT ^ 1023, "R5 primed");

        // R7 / R8: walk chooser entries through all states and pairs, both saturation ends
        for (int x = 5; x < 30; x += 12) begin
            for (int s = 0; s < 16; s++) begin
                pair(x, seq[s], s[0]);
                look(x, G_HOT ^ x, "R8 chooser p2=1");
                look(x, G_ICE ^ x, "R7 chooser p2=0");
            end
        end

        // R10: invalid updates change nothing
        for (int k = 0; k < 6; k++) begin
            upd(5, G_HOT ^ 5, k[0], 1'b1, 1'b0, 1'b0);
            look(5, G_HOT ^ 5, "R10 idle");
            look(5, G_ICE ^ 5, "R10 idle");
        end

        // R4 / R9: local history and both tables trained together on a loop-like pattern
        for (int k = 0; k < 40; k++) begin
            bit tk;
            tk = (k % 4) != 3;
            look(200, 77, "R4 loop");
            upd(200, 77, tk, e_p1(200), e_p2(200, 77), 1'b1);
        end

        // mixed traffic, predictions fed back as on a real pipeline
        lfsr = 32'h1ACE5EED;
        for (int k = 0; k < 2500; k++) begin
            int pc, gh;
            bit tk;
            lfsr = (lfsr << 1) ^ ((lfsr < 0) ? 32'h04C11DB7 : 0);
            pc = (lfsr & 32'h7) | (((lfsr >> 4) & 32'h3) << 6) | (((lfsr >> 8) & 32'h3) << 8);
            gh = (lfsr >> 12) & 32'h3FF;
            tk = ((lfsr >> 24) & 32'h3) != 0;
            look(pc, gh, "R9 mixed");
            if (k % 5 == 0)
                upd(pc, gh, tk, lfsr[28], lfsr[29], 1'b1);
            else
                upd(pc, gh, tk, e_p1(pc), e_p2(pc, gh), 1'b1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule